// File: doc/BRIEF.md
# Dual-Buffer Sequential Address Pointer

This block produces the address for a sequentially accessed memory of 2^AW words. A pointer steps by one on every clock edge where the count enable is high. Two buffer regions can be placed anywhere in the address space. Each region has its own start address, its own end address and its own end action. When the pointer sits on a region's end address, it can do one of two things. In chain mode it moves to the start of the other region. In stop mode it parks and blocks sequential writes until software frees it.

Each end address has a latched end-of-buffer flag. The flags drive two active-low outputs and can be read and cleared through a status register. All configuration goes through a small synchronous register port with a 3-bit address. The same port carries two commands: load the pointer with a value, and jump to the start of either region.

Top module: `seq_addr_ptr`

## Requirements
- R1: While the asynchronous active-low reset is applied, the pointer, all four address registers, the flow register and both flags are cleared. After release, reads return 0 at addresses 0-4 and 6, 0xFFFC at address 5 and 0xFFFF at address 7.
- R2: When no register write takes place and the pointer is running and not on an end address, each clock edge with cntEn high adds one to the pointer, wrapping from 0xFFF to 0x000. With cntEn low the pointer holds.
- R3: The register map is: 0 = start of buffer 1, 1 = end of buffer 1, 2 = start of buffer 2, 3 = end of buffer 2, 4 = flow register, 5 = flag status, 6 = pointer. Address registers and the pointer read back zero-extended. Bits above AW are ignored on writes. The flow register keeps 5 bits: [1:0] is buffer 1 mode, [3:2] is buffer 2 mode, [4] is release. A write to 6 loads the pointer. A write to 7 jumps to the start of buffer 1 (data bit 0 = 0) or buffer 2 (bit 0 = 1). A read of 7 returns all ones.
- R4: On the edge where the pointer takes a value equal to an end address, that buffer's flag is set. Its output (eob1N or eob2N) goes low on that edge and stays low until the flag is cleared.
- R5: In mode 00 (chain), an enabled edge with the pointer on buffer 1's end loads buffer 2's start. An enabled edge with the pointer on buffer 2's end loads buffer 1's start.
- R6: If both end addresses are equal, reaching that value sets both flags on the same edge. In chain mode the next enabled edge then loads buffer 1's start. With both ends equal, buffer 1's mode governs.
- R7: In mode 01 (stop), the first edge with the pointer on that end halts the pointer. The pointer parks at end+1 if cntEn is high on that edge, otherwise at the end address. While halted, cntEn has no effect and `halted` is high.
- R8: memWrEn follows wrReq, except that it is forced low while the pointer is halted.
- R9: Writing the flow register with bit 4 = 0 while halted releases the pointer. The next edge must have cntEn high, and it moves the pointer to end+2. If cntEn is low on that edge, the pointer stays halted. A write with bit 4 = 1 does not release.
- R10: A pointer load (address 6) or a start jump (address 7) also releases a halted pointer, and counting continues from the new value.
- R11: Reading address 5 returns bit 0 = buffer 1 flag and bit 1 = buffer 2 flag, with all other bits 1.
- R12: Writing address 5 clears a flag whose data bit (0 or 1) is 0 and leaves a flag whose bit is 1 unchanged. Either flag or both can be cleared in one write.
- R13: Modes 10 and 11 take no end action. The pointer just steps past the end address, but the flag is still set on arrival.
- R14: A register write on the same edge as cntEn wins: the pointer does not count on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count enable for the pointer |
| wrReq | input | 1 | Sequential write request from the access side |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | DW | Register write data |
| regRdata | output | DW | Register read data (combinational on regAddr) |
| ptr | output | AW | Current pointer address |
| memWrEn | output | 1 | Qualified memory write enable |
| halted | output | 1 | Pointer parked by stop mode |
| eob1N | output | 1 | Buffer 1 end flag, active low |
| eob2N | output | 1 | Buffer 2 end flag, active low |

## Verification
Pointer, flags and `halted` all change on the edge that samples the stimulus. The bench therefore drives inputs 1 time unit after a rising edge and reads these outputs 1 time unit after the next rising edge. Stop-mode release is the one two-edge sequence: the flow write edge, then the edge that moves the pointer to end+2. The bench checks the state after each of the two edges separately. regRdata and memWrEn are combinational, so the bench checks them 1 time unit after changing regAddr or wrReq, with no clock edge in between.

// File: rtl/seq_addr_ptr_pkg.sv
package seq_addr_ptr_pkg;

  // register port addresses
  localparam logic [2:0] ADDR_START1 = 3'd0;
  localparam logic [2:0] ADDR_END1   = 3'd1;
  localparam logic [2:0] ADDR_START2 = 3'd2;
  localparam logic [2:0] ADDR_END2   = 3'd3;
  localparam logic [2:0] ADDR_FLOW   = 3'd4;
  localparam logic [2:0] ADDR_FLAG   = 3'd5;
  localparam logic [2:0] ADDR_PTR    = 3'd6;

  localparam int FLOW_W = 5;
  localparam int REL_BIT = 4;

  localparam logic [1:0] MODE_CHAIN = 2'b00;
  localparam logic [1:0] MODE_STOP  = 2'b01;

  typedef enum logic [2:0] {
    PTR_HOLD,
    PTR_STEP,
    PTR_LOAD,
    PTR_GO1,
    PTR_GO2,
    PTR_SKIP
  } ptrOp_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_HALT,
    ST_REL
  } runState_e;

  // strobes from control to datapath
  typedef struct packed {
    ptrOp_e     ptrOp;
    logic [3:0] cfgWr;   // [0] start1 [1] end1 [2] start2 [3] end2
    logic [1:0] flagClr;
    logic       grabEnd;
  } dpCmd_t;

endpackage

// File: rtl/seq_addr_ptr_ctrl.sv
module seq_addr_ptr_ctrl
  import seq_addr_ptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [FLOW_W-1:0] wrLow,
  input  logic [1:0]        hit,
  output dpCmd_t            cmd,
  output logic [FLOW_W-1:0] flowCfg,
  output logic              halted,
  output logic              skipPend
);

  runState_e         stQ, stD;
  logic [FLOW_W-1:0] flowQ, flowD;
  logic [1:0]        selMode;
  logic              anyHit;

  assign anyHit  = |hit;
  // buffer 1 governs when both ends match
  assign selMode = hit[0] ? flowQ[1:0] : flowQ[3:2];

  always_comb begin
    cmd       = '0;
    cmd.ptrOp = PTR_HOLD;
    stD       = stQ;
    flowD     = flowQ;
    if (regWr) begin
      unique case (regAddr)
        ADDR_START1: cmd.cfgWr[0] = 1'b1;
        ADDR_END1:   cmd.cfgWr[1] = 1'b1;
        ADDR_START2: cmd.cfgWr[2] = 1'b1;
        ADDR_END2:   cmd.cfgWr[3] = 1'b1;
        ADDR_FLOW: begin
          flowD = wrLow;
          if (stQ == ST_HALT && !wrLow[REL_BIT]) stD = ST_REL;
        end
        ADDR_FLAG: cmd.flagClr = ~wrLow[1:0];
        ADDR_PTR: begin
          cmd.ptrOp = PTR_LOAD;
          stD       = ST_RUN;
        end
        default: begin
          cmd.ptrOp = wrLow[0] ? PTR_GO2 : PTR_GO1;
          stD       = ST_RUN;
        end
      endcase
    end else begin
      unique case (stQ)
        ST_HALT: ;
        ST_REL: begin
          if (cntEn) begin
            cmd.ptrOp = PTR_SKIP;
            stD       = ST_RUN;
          end else begin
            stD = ST_HALT;
          end
        end
        default: begin
          if (anyHit && selMode == MODE_STOP) begin
            cmd.grabEnd = 1'b1;
            stD         = ST_HALT;
            if (cntEn) cmd.ptrOp = PTR_STEP;
          end else if (cntEn) begin
            if (anyHit && selMode == MODE_CHAIN)
              cmd.ptrOp = (hit == 2'b01) ? PTR_GO2 : PTR_GO1;
            else
              cmd.ptrOp = PTR_STEP;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_RUN;
      flowQ <= '0;
    end else begin
      stQ   <= stD;
      flowQ <= flowD;
    end
  end

  assign flowCfg  = flowQ;
  assign halted   = (stQ == ST_HALT);
  assign skipPend = (stQ == ST_REL);

endmodule

// File: rtl/seq_addr_ptr_dp.sv
module seq_addr_ptr_dp
  import seq_addr_ptr_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [AW-1:0]     wrAddr,
  input  logic [2:0]        rdAddr,
  input  logic [FLOW_W-1:0] flowCfg,
  output logic [AW-1:0]     ptr,
  output logic [1:0]        hit,
  output logic [1:0]        flag,
  output logic [AW-1:0]     end1,
  output logic [AW-1:0]     end2,
  output logic [DW-1:0]     rdData
);

  localparam int PAD = DW - AW;
  localparam int NBUF = 2;

  logic [AW-1:0] startQ [NBUF];
  logic [AW-1:0] endQ   [NBUF];
  logic [AW-1:0] ptrQ, ptrD, haltEndQ;
  logic          landed;

  always_comb begin
    unique case (cmd.ptrOp)
      PTR_STEP: ptrD = ptrQ + AW'(1);
      PTR_LOAD: ptrD = wrAddr;
      PTR_GO1:  ptrD = startQ[0];
      PTR_GO2:  ptrD = startQ[1];
      PTR_SKIP: ptrD = haltEndQ + AW'(2);
      default:  ptrD = ptrQ;
    endcase
  end

  assign landed = (cmd.ptrOp != PTR_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ     <= '0;
      haltEndQ <= '0;
    end else begin
      ptrQ <= ptrD;
      if (cmd.grabEnd) haltEndQ <= ptrQ;
    end
  end

  generate
    for (genvar b = 0; b < NBUF; b++) begin : g_buf
      logic flagQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          startQ[b] <= '0;
          endQ[b]   <= '0;
          flagQ     <= 1'b0;
        end else begin
          if (cmd.cfgWr[2*b])   startQ[b] <= wrAddr;
          if (cmd.cfgWr[2*b+1]) endQ[b]   <= wrAddr;
          if (landed && ptrD == endQ[b]) flagQ <= 1'b1;
          else if (cmd.flagClr[b])       flagQ <= 1'b0;
        end
      end
      assign hit[b]  = (ptrQ == endQ[b]);
      assign flag[b] = flagQ;
    end
  endgenerate

  always_comb begin
    unique case (rdAddr)
      ADDR_START1: rdData = {{PAD{1'b0}}, startQ[0]};
      ADDR_END1:   rdData = {{PAD{1'b0}}, endQ[0]};
      ADDR_START2: rdData = {{PAD{1'b0}}, startQ[1]};
      ADDR_END2:   rdData = {{PAD{1'b0}}, endQ[1]};
      ADDR_FLOW:   rdData = {{(DW-FLOW_W){1'b0}}, flowCfg};
      ADDR_FLAG:   rdData = {{(DW-2){1'b1}}, flag};
      ADDR_PTR:    rdData = {{PAD{1'b0}}, ptrQ};
      default:     rdData = '1;
    endcase
  end

  assign ptr  = ptrQ;
  assign end1 = endQ[0];
  assign end2 = endQ[1];

endmodule

// File: rtl/seq_addr_ptr.sv
module seq_addr_ptr
  import seq_addr_ptr_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cntEn,
  input  logic          wrReq,
  input  logic          regWr,
  input  logic [2:0]    regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic [AW-1:0] ptr,
  output logic          memWrEn,
  output logic          halted,
  output logic          eob1N,
  output logic          eob2N
);

  dpCmd_t            cmd;
  logic [FLOW_W-1:0] flowCfg;
  logic [1:0]        hit, flag;
  logic [AW-1:0]     end1, end2;
  logic              skipPend;

  seq_addr_ptr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cntEn    (cntEn),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .wrLow    (regWdata[FLOW_W-1:0]),
    .hit      (hit),
    .cmd      (cmd),
    .flowCfg  (flowCfg),
    .halted   (halted),
    .skipPend (skipPend)
  );

  seq_addr_ptr_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .wrAddr  (regWdata[AW-1:0]),
    .rdAddr  (regAddr),
    .flowCfg (flowCfg),
    .ptr     (ptr),
    .hit     (hit),
    .flag    (flag),
    .end1    (end1),
    .end2    (end2),
    .rdData  (regRdata)
  );

  assign memWrEn = wrReq & ~halted;
  assign eob1N   = ~flag[0];
  assign eob2N   = ~flag[1];

endmodule

// File: rtl/seq_addr_ptr_chk.sv
module seq_addr_ptr_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          cntEn,
  input logic          wrReq,
  input logic          regWr,
  input logic [2:0]    regAddr,
  input logic [DW-1:0] regWdata,
  input logic [AW-1:0] ptr,
  input logic [AW-1:0] end1,
  input logic [AW-1:0] end2,
  input logic          memWrEn,
  input logic          halted,
  input logic          skipPend,
  input logic          eob1N
);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !halted && !skipPend && !regWr && ptr != end1 && ptr != end2)
    |=> (ptr == AW'($past(ptr) + AW'(1))));

  // R7
  halt_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !regWr) |=> $stable(ptr));

  // R8
  wr_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && wrReq) |-> !memWrEn);

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eob1N && !(regWr && regAddr == 3'd5 && !regWdata[0])) |=> !eob1N);

  // R14
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 3'd6) |=> (ptr == $past(regWdata[AW-1:0])));

endmodule

bind seq_addr_ptr seq_addr_ptr_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cntEn    (cntEn),
  .wrReq    (wrReq),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .ptr      (ptr),
  .end1     (end1),
  .end2     (end2),
  .memWrEn  (memWrEn),
  .halted   (halted),
  .skipPend (skipPend),
  .eob1N    (eob1N)
);

// File: tb/seq_addr_ptr_tb.sv
module seq_addr_ptr_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cntEn = 1'b0;
  logic          wrReq = 1'b0;
  logic          regWr = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic [AW-1:0] ptr;
  logic          memWrEn, halted, eob1N, eob2N;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_addr_ptr #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrReq(wrReq), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .ptr(ptr),
    .memWrEn(memWrEn), .halted(halted), .eob1N(eob1N), .eob2N(eob2N)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic regW(input logic [2:0] a, input logic [DW-1:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    edge1();
    regWr = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [DW-1:0] exp);
    regAddr = a;
    #1;
    chk(req, 32'(regRdata), 32'(exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chk("R1 ptr", 32'(ptr), 0);
    chk("R1 eob1N", 32'(eob1N), 1);
    chk("R1 eob2N", 32'(eob2N), 1);
    for (int a = 0; a < 7; a++)
      if (a != 5) rdChk("R1 reg", 3'(a), 16'h0000);
    rdChk("R11 status reset", 3'd5, 16'hFFFC);
    rdChk("R3 addr7", 3'd7, 16'hFFFF);

    // R3 program and read back
    regW(3'd0, 16'h0100);
    regW(3'd1, 16'h010F);
    regW(3'd2, 16'h0200);
    regW(3'd3, 16'hF20F);
    rdChk("R3 start1", 3'd0, 16'h0100);
    rdChk("R3 end1", 3'd1, 16'h010F);
    rdChk("R3 start2", 3'd2, 16'h0200);
    rdChk("R3 end2 upper ignored", 3'd3, 16'h020F);
    regW(3'd7, 16'h0000);
    chk("R3 go start1", 32'(ptr), 32'h100);

    // R2 sweep through buffer 1
    cntEn = 1'b1;
    for (int i = 1; i <= 15; i++) begin
      edge1();
      chk("R2 step", 32'(ptr), 32'(12'h100 + i));
      if (i < 15) chk("R4 no flag early", 32'(eob1N), 1);
    end
    chk("R4 eob1 set", 32'(eob1N), 0);
    cntEn = 1'b0;
    edge1();
    chk("R2 hold", 32'(ptr), 32'h10F);
    // R5 chain to buffer 2
    cntEn = 1'b1;
    edge1();
    chk("R5 chain 1->2", 32'(ptr), 32'h200);
    chk("R4 eob1 stays", 32'(eob1N), 0);
    repeat (15) edge1();
    chk("R4 eob2 set", 32'(eob2N), 0);
    edge1();
    chk("R5 chain 2->1", 32'(ptr), 32'h100);
    cntEn = 1'b0;

    // R11 / R12 status
    rdChk("R11 both set", 3'd5, 16'hFFFF);
    regW(3'd5, 16'hFFFE);
    chk("R12 clr1 eob1N", 32'(eob1N), 1);
    chk("R12 keep2 eob2N", 32'(eob2N), 0);
    rdChk("R11 only flag2", 3'd5, 16'hFFFE);
    regW(3'd5, 16'h0000);
    chk("R12 clr both", 32'({eob1N, eob2N}), 32'h3);

    // R14 write wins, R2 wrap
    cntEn = 1'b1;
    regW(3'd6, 16'hFFFE);
    chk("R14 load over count", 32'(ptr), 32'hFFE);
    edge1();
    chk("R2 step FFF", 32'(ptr), 32'hFFF);
    edge1();
    chk("R2 wrap", 32'(ptr), 32'h000);
    cntEn = 1'b0;
    wrReq = 1'b1;
    #1 chk("R8 write allowed", 32'(memWrEn), 1);

    // R7 stop at end+1
    regW(3'd4, 16'h0005);
    regW(3'd6, 16'h010D);
    cntEn = 1'b1;
    edge1(); edge1();
    chk("R7 at end", 32'(ptr), 32'h10F);
    edge1();
    chk("R7 park end+1", 32'(ptr), 32'h110);
    chk("R7 halted", 32'(halted), 1);
    chk("R8 write blocked", 32'(memWrEn), 0);
    edge1(); edge1();
    chk("R7 no move", 32'(ptr), 32'h110);
    cntEn = 1'b0;
    regW(3'd4, 16'h0015);
    rdChk("R3 flow read", 3'd4, 16'h0015);
    cntEn = 1'b1;
    edge1();
    chk("R9 bit4=1 no release", 32'(ptr), 32'h110);
    chk("R9 still halted", 32'(halted), 1);
    cntEn = 1'b0;
    regW(3'd4, 16'h0005);
    chk("R9 released", 32'(halted), 0);
    cntEn = 1'b1;
    edge1();
    chk("R9 end+2", 32'(ptr), 32'h111);
    chk("R8 write again", 32'(memWrEn), 1);
    cntEn = 1'b0;

    // R7 stop at end, R9 missed enable
    regW(3'd6, 16'h010E);
    cntEn = 1'b1;
    edge1();
    cntEn = 1'b0;
    edge1();
    chk("R7 park at end", 32'(ptr), 32'h10F);
    chk("R7 halted at end", 32'(halted), 1);
    regW(3'd4, 16'h0005);
    edge1();
    chk("R9 no enable rehalt", 32'(halted), 1);
    cntEn = 1'b1;
    edge1();
    chk("R9 stays parked", 32'(ptr), 32'h10F);
    cntEn = 1'b0;
    regW(3'd4, 16'h0005);
    cntEn = 1'b1;
    edge1();
    chk("R9 end+2 from end", 32'(ptr), 32'h111);
    cntEn = 1'b0;

    // R10 other releases, buffer 2 stop
    regW(3'd7, 16'h0001);
    chk("R3 go start2", 32'(ptr), 32'h200);
    cntEn = 1'b1;
    repeat (16) edge1();
    chk("R7 buf2 halted", 32'(halted), 1);
    chk("R7 buf2 end+1", 32'(ptr), 32'h210);
    cntEn = 1'b0;
    regW(3'd7, 16'h0001);
    chk("R10 start cmd release", 32'(halted), 0);
    chk("R10 start cmd ptr", 32'(ptr), 32'h200);
    cntEn = 1'b1;
    repeat (16) edge1();
    cntEn = 1'b0;
    chk("R7 halted again", 32'(halted), 1);
    regW(3'd6, 16'h0050);
    chk("R10 load release", 32'(halted), 0);
    cntEn = 1'b1;
    edge1();
    chk("R10 counts after load", 32'(ptr), 32'h051);
    cntEn = 1'b0;

    // R6 equal ends, chain
    regW(3'd4, 16'h0000);
    regW(3'd3, 16'h010F);
    regW(3'd5, 16'h0000);
    regW(3'd6, 16'h010E);
    cntEn = 1'b1;
    edge1();
    chk("R6 both flags", 32'({eob1N, eob2N}), 0);
    edge1();
    chk("R6 jump start1", 32'(ptr), 32'h100);
    cntEn = 1'b0;

    // R13 reserved mode
    regW(3'd4, 16'h0002);
    regW(3'd5, 16'h0000);
    regW(3'd6, 16'h010E);
    cntEn = 1'b1;
    edge1();
    chk("R13 flag on arrival", 32'(eob1N), 0);
    edge1();
    chk("R13 step past end", 32'(ptr), 32'h110);
    chk("R13 not halted", 32'(halted), 0);
    cntEn = 1'b0;

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule